// File: doc/BRIEF.md
# LFSR Memory Fill Engine

This block loads a 256-entry, byte-wide RAM with pseudorandom data. A one-cycle start pulse starts a fill run. The block then drives the RAM write port directly with an address, a data byte and a write strobe. It visits every location once, from address 0x00 up to 0xFF. When the run is over it drops busy and pulses done.

The data comes from an 8-bit Fibonacci shift register with XOR feedback. Its feedback polynomial is x^8+x^6+x^5+x^4+1, so it steps through all 255 nonzero states before it repeats. Between two stored bytes the register advances eight times, so each stored byte is made of entirely fresh bits rather than a one-bit shift of the byte before it.

The asynchronous reset loads a fixed nonzero seed, one preset or clear value per register bit. A later run without a reset continues from where the previous run stopped. A run that follows a reset therefore always produces the same memory image.

Top module: `lfsr_mem_fill`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o, done_o and we_o are 0, and the shift register holds the seed SEED (default 0x01).
- R2: Each step shifts the register toward the MSB and puts b7^b5^b4^b3 into bit 0. The byte written for each location is the register state after eight more steps.
- R3: During a run, the write addresses are 0x00, 0x01, …, 0xFF in increasing order, each exactly once.
- R4: Start is sampled at a clock edge E0. The first we_o pulse follows edge E8. Each later write comes exactly 8 clocks after the one before it, and every we_o pulse lasts one cycle.
- R5: done_o is high for exactly one cycle, in the cycle right after the write to 0xFF. busy_o falls at the same edge.
- R6: busy_o is 1 from the edge that accepts start until the last write, inclusive.
- R7: A start pulse, or a held start, while busy_o is 1 has no effect on addresses, data, timing or done.
- R8: A new run without a reset continues the register sequence where the previous run stopped. It does not reseed.
- R9: Asserting rst_ni in the middle of a run aborts it at once. The next run produces the same image as the first run after reset.
- R10: No written byte is 0x00. Because the period is 255, the byte at 0xFF equals the byte at 0x00 in a run that starts from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, loads the seed |
| start_i | input | 1 | Start a fill run (sampled while idle) |
| addr_o | output | 8 | RAM write address |
| wdata_o | output | 8 | RAM write data |
| we_o | output | 1 | RAM write strobe |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
Each run's memory image is rebuilt write by write and compared to a bench model of the feedback polynomial. The comparison covers data, address order and the cycle of every write.

The start input is driven in several patterns:
- A clean pulse after a random idle gap. This separates a correct seed and correct taps from nearly right ones.
- Random extra pulses during a run. These show whether a busy-time start restarts the counters.
- Start held high for the whole run. This catches a block that re-triggers on its last cycle.

A second run with no reset in between separates continuation from reseeding. A reset in the middle of a run, followed by a fresh run, shows whether the seed is truly restored. Comparing the bytes at 0x00 and 0xFF checks the 255-state period.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fill_lfsr.sv
module fill_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'b1011_1000,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb = ^(q & TAPS);

  // one flop per bit, each with its own preset/clear seed value
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic d;
    if (i == 0) begin : g_in
      assign d = fb;
    end else begin : g_sh
      assign d = q[i-1];
    end
    assign next_o[i] = d;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q[i] <= SEED[i];
      else if (step_i) q[i] <= d;
    end
  end

  assign state_o = q;
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int STEPS  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              step_o,
  output logic              word_end_o,
  output logic [ADDR_W-1:0] word_idx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0]     STEP_LAST = CW'(STEPS - 1);
  localparam logic [ADDR_W-1:0] WORD_LAST = {ADDR_W{1'b1}};

  fill_state_e       state_q;
  logic [CW-1:0]     step_q;
  logic [ADDR_W-1:0] word_q;
  logic              done_q;
  logic              word_end;

  assign word_end = (state_q == ST_RUN) && (step_q == STEP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            step_q  <= '0;
            word_q  <= '0;
          end
        end
        ST_RUN: begin
          step_q <= word_end ? '0 : step_q + 1'b1;
          if (word_end) begin
            word_q <= word_q + 1'b1;
            if (word_q == WORD_LAST) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o     = (state_q == ST_RUN);
  assign word_end_o = word_end;
  assign word_idx_o = word_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/fill_wr.sv
module fill_wr #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_end_i,
  input  logic [ADDR_W-1:0] word_idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
    end else begin
      we_o <= word_end_i;
      if (word_end_i) begin
        addr_o  <= word_idx_i;
        wdata_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/lfsr_mem_fill.sv
module lfsr_mem_fill #(
  parameter int               ADDR_W = 8,
  parameter int               DATA_W = 8,
  parameter int               STEPS  = DATA_W,
  parameter logic [DATA_W-1:0] TAPS  = 8'b1011_1000,
  parameter logic [DATA_W-1:0] SEED  = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              step;
  logic              word_end;
  logic [ADDR_W-1:0] word_idx;
  logic [DATA_W-1:0] lfsr_q;
  logic [DATA_W-1:0] lfsr_d;

  fill_seq #(.STEPS(STEPS), .ADDR_W(ADDR_W)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .step_o     (step),
    .word_end_o (word_end),
    .word_idx_o (word_idx),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  fill_lfsr #(.W(DATA_W), .TAPS(TAPS), .SEED(SEED)) lfsr_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .state_o (lfsr_q),
    .next_o  (lfsr_d)
  );

  fill_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_end_i (word_end),
    .word_idx_i (word_idx),
    .data_i     (lfsr_d),
    .addr_o     (addr_o),
    .wdata_o    (wdata_o),
    .we_o       (we_o)
  );

  logic unused_q;
  assign unused_q = ^lfsr_q;
endmodule

// File: rtl/fill_chk.sv
module fill_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int STEPS  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              we_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int GW = $clog2(STEPS) + 2;

  logic [GW-1:0]     gap_q;
  logic              seen_q;
  logic [ADDR_W-1:0] last_addr_q;

  // window counter instead of a parameter-deep $past
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      seen_q      <= 1'b0;
      last_addr_q <= '0;
    end else begin
      if (we_o) begin
        gap_q       <= '0;
        seen_q      <= 1'b1;
        last_addr_q <= addr_o;
      end else if (gap_q != {GW{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
      if (done_o) seen_q <= 1'b0;
    end
  end

  assert_write_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && seen_q) |-> (gap_q == GW'(STEPS - 1)));
  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && seen_q) |-> (addr_o == last_addr_q + 1'b1));
  assert_first_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !seen_q) |-> (addr_o == '0));
  assert_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wdata_o != '0));
  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_we_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> busy_o);
  assert_start_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !we_o) |=> busy_o);
endmodule

bind lfsr_mem_fill fill_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEPS(STEPS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .addr_o  (addr_o),
  .wdata_o (wdata_o),
  .we_o    (we_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/lfsr_mem_fill_tb_top.sv
module lfsr_mem_fill_tb_top;
  localparam int WORDS = 256;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] addr_o, wdata_o;
  logic       we_o, busy_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [7:0] wr_addr [WORDS];
  logic [7:0] wr_data [WORDS];
  int         wr_cyc  [WORDS];
  int         n_wr, n_done, done_cyc;
  logic [7:0] run1_img [WORDS];
  logic [7:0] model;

  lfsr_mem_fill dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .we_o(we_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (we_o) begin
      if (n_wr < WORDS) begin
        wr_addr[n_wr] = addr_o;
        wr_data[n_wr] = wdata_o;
        wr_cyc[n_wr]  = cyc;
      end
      n_wr = n_wr + 1;
    end
    if (done_o) begin
      n_done   = n_done + 1;
      done_cyc = cyc;
    end
  end

  function automatic logic [7:0] step8(input logic [7:0] s);
    logic [7:0] t = s;
    for (int i = 0; i < 8; i++) t = {t[6:0], t[7] ^ t[5] ^ t[4] ^ t[3]};
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: single pulse, 1: random extra pulses, 2: start held high
  task automatic run_fill(input int mode, input int gap, output int st);
    repeat (gap) @(negedge clk);
    n_wr = 0; n_done = 0; done_cyc = -1;
    start_i = 1'b1;
    st = cyc;
    @(negedge clk);
    start_i = (mode == 2);
    chk(busy_o === 1'b1, "R6 busy after start", busy_o, 1);
    while (busy_o === 1'b1 && cyc < st + 4000) begin
      if (mode == 1) start_i = ($urandom_range(0, 15) == 0);
      @(negedge clk);
      if (busy_o !== 1'b1) start_i = 1'b0;
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_run(input int st, input string tag);
    int bad_d = 0, bad_a = 0, bad_t = 0, zero = 0;
    chk(n_wr == WORDS, {tag, " R3 write count"}, n_wr, WORDS);
    for (int k = 0; k < WORDS; k++) begin
      model = step8(model);
      if (wr_data[k] !== model) begin
        bad_d++;
        if (bad_d == 1) chk(1'b0, {tag, " R2 data"}, wr_data[k], model);
      end
      if (wr_addr[k] !== 8'(k)) bad_a++;
      if (wr_cyc[k] != st + 9 + 8 * k) bad_t++;
      if (wr_data[k] == 8'h00) zero++;
    end
    chk(bad_d == 0, {tag, " R2 data mismatches"}, bad_d, 0);
    chk(bad_a == 0, {tag, " R3 address order"}, bad_a, 0);
    chk(bad_t == 0, {tag, " R4 write timing"}, bad_t, 0);
    chk(wr_cyc[0] == st + 9, {tag, " R4 first write latency"}, wr_cyc[0] - st, 9);
    chk(zero == 0, {tag, " R10 nonzero data"}, zero, 0);
    chk(n_done == 1, {tag, " R5 single done pulse"}, n_done, 1);
    chk(done_cyc == st + 9 + 8 * 255 + 1, {tag, " R5 done cycle"}, done_cyc - st, 9 + 8 * 255 + 1);
    chk(busy_o === 1'b0, {tag, " R5 busy low at end"}, busy_o, 0);
  endtask

  initial begin
    int st;
    void'($urandom(32'd448));
    n_wr = 0; n_done = 0; done_cyc = -1;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && we_o === 1'b0, "R1 outputs in reset",
        {busy_o, done_o, we_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && we_o === 1'b0, "R1 idle after reset",
        {busy_o, done_o, we_o}, 0);
    chk(n_wr == 0, "R1 no writes before start", n_wr, 0);

    // run 1 from the seed, random ignored starts (R7)
    model = 8'h01;
    run_fill(1, $urandom_range(1, 20), st);
    check_run(st, "run1 R7");
    for (int k = 0; k < WORDS; k++) run1_img[k] = wr_data[k];
    chk(wr_data[255] === wr_data[0], "R10 period: word 0xFF equals word 0x00", wr_data[255], wr_data[0]);

    // run 2, no reset: sequence continues (R8), start held high (R7)
    run_fill(2, $urandom_range(1, 20), st);
    check_run(st, "run2 R8");
    chk(wr_data[0] === run1_img[1], "R8 continues, not reseeded", wr_data[0], run1_img[1]);

    // run 3 aborted by reset (R9)
    n_wr = 0;
    @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat ($urandom_range(50, 300)) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(busy_o === 1'b0 && we_o === 1'b0, "R9 reset aborts run", {busy_o, we_o}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(busy_o === 1'b0, "R9 stays idle after abort", busy_o, 0);

    // run 4 reproduces run 1
    model = 8'h01;
    run_fill(0, $urandom_range(1, 20), st);
    check_run(st, "run4 R9");
    begin
      int diff = 0;
      for (int k = 0; k < WORDS; k++) if (wr_data[k] !== run1_img[k]) diff++;
      chk(diff == 0, "R9 image matches first run", diff, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule